// File: doc/BRIEF.md
# USB Control Setup Request Bridge

This block sits behind the endpoint-0 receive logic of a USB device controller. It takes each 8-byte setup packet as a byte stream (valid/ready) and sorts it. A vendor register read or a vendor register write is carried out directly on a byte-wide internal register bus. A read returns one byte in a data stage. A read whose length field is wrong is refused with a stall pulse. A write has no data stage.

A Get Descriptor request, or any vendor request that is not a register access, is copied into an 8-byte buffer for firmware, and a level interrupt is raised. Firmware reads that buffer through a 3-bit byte index and clears the interrupt with a strobe. Other standard requests and all class requests pass through without touching the bus, the buffer or the interrupt, because other logic completes them.

The setup stream is byte-serial, and its back-pressure rules are as follows:
- A byte moves on every clock edge where `setup_valid` and `setup_ready` are both high.
- The eighth byte completes a packet. After it, `setup_ready` stays low while the packet is decoded, while a register read is in flight, and while a data-stage byte waits for the consumer.
- The data stage is a one-byte valid/ready output. `in_data` is held stable until it is taken.

Multi-byte fields are little-endian. The packet bytes are, in order: request type, request code, value low, value high, index low, index high, length low, length high.

Top module: `usb_setup_bridge`

## Requirements
- R1: After reset `setup_ready` is 1, `in_valid` is 0, `fw_irq` is 0 and no bus strobe is active. A setup byte is accepted only when `setup_valid` and `setup_ready` are both high. `setup_ready` is 0 from the eighth byte until the request has finished, including the whole time `in_valid` is 1.
- R2: A packet with type 0xC0, code 0x00 and length 1 gives one single-cycle `reg_rd` pulse, with `reg_addr` set to the index field (byte 4 low, byte 5 high). On the next cycle `in_valid` rises, and `in_data` equals the `reg_rdata` value present during the pulse. `in_valid` and `in_data` hold until `in_ready` is seen high.
- R3: A packet with type 0xC0, code 0x00 and a length other than 1 gives a one-cycle `ctl_stall` pulse. It gives no `reg_rd`, no data stage and no interrupt.
- R4: A packet with type 0x41 and code 0x00 gives exactly one single-cycle `reg_wr` pulse. During that pulse, `reg_addr` is the index field and `reg_wdata` is byte 2. The value high byte is ignored. There is no data stage and no interrupt.
- R5: A standard request (type bits 6:5 = 00) with code 0x06, or any vendor request (type bits 6:5 = 10) not covered by R2–R4, is copied whole into the firmware buffer and sets `fw_irq`.
- R6: `fw_byte` shows buffer byte `fw_idx`, where index 0 is the request type and index 7 is the length high byte.
- R7: `fw_irq` stays 1 until a `fw_irq_clr` strobe. A later forwarded packet overwrites the buffer and sets `fw_irq` again, even if the flag was not cleared.
- R8: Any other packet (other standard requests, class requests) leaves the buffer, `fw_irq`, `reg_rd`, `reg_wr` and `ctl_stall` unchanged, and `setup_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | Setup byte present |
| setup_ready | output | 1 | Bridge can take a setup byte |
| setup_data | input | 8 | Setup byte |
| in_valid | output | 1 | Data-stage byte present |
| in_ready | input | 1 | Consumer takes data-stage byte |
| in_data | output | 8 | Data-stage byte (register read result) |
| ctl_stall | output | 1 | One-cycle stall indication |
| reg_addr | output | 16 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Register bus write strobe |
| reg_rd | output | 1 | Register bus read strobe |
| reg_rdata | input | 8 | Register bus read data, valid during `reg_rd` |
| fw_irq | output | 1 | Interrupt to firmware |
| fw_irq_clr | input | 1 | Firmware clear strobe for `fw_irq` |
| fw_idx | input | 3 | Firmware buffer byte index |
| fw_byte | output | 8 | Firmware buffer byte at `fw_idx` |

## Verification
The hardest case to reach is a setup producer that keeps pushing bytes while a read result sits unconsumed in the data stage. If one such byte were taken, every later packet would be misaligned. The bench reaches this case by holding `in_ready` low for several cycles after a register read, while it drives `setup_valid` high with junk bytes. It then confirms the data byte stayed put. It also sends a register write and checks that it decodes exactly. A second case that is hard to reach is a forwarded packet that arrives while the interrupt is still pending. The bench sends two such packets back to back without a clear.

// File: rtl/usb_setup_pkg.sv
package usb_setup_pkg;
  localparam int SETUP_BYTES = 8;
  localparam int SETUP_BITS  = 8 * SETUP_BYTES;
  localparam int IDX_W       = $clog2(SETUP_BYTES);
  localparam int ADDR_W      = 16;

  localparam logic [7:0] TYPE_REG_RD  = 8'hC0;
  localparam logic [7:0] TYPE_REG_WR  = 8'h41;
  localparam logic [7:0] CODE_REG     = 8'h00;
  localparam logic [7:0] CODE_GET_DESC = 8'h06;
  localparam logic [1:0] KIND_STD     = 2'b00;
  localparam logic [1:0] KIND_VENDOR  = 2'b10;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_RD, CLS_STALL, CLS_WR, CLS_FWD
  } req_class_t;

  typedef enum logic [1:0] {
    ST_COLLECT, ST_EXEC, ST_RDCAP, ST_RESP
  } bridge_state_t;
endpackage

// File: rtl/setup_collector.sv
module setup_collector
  import usb_setup_pkg::*;
#(
  parameter int NBYTES = SETUP_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [7:0]            din,
  output logic [8*NBYTES-1:0]   flat,
  output logic                  frame_done
);
  localparam int CNT_W = $clog2(NBYTES);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last    = (cnt == CNT_W'(NBYTES - 1));
  assign frame_done = take && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (take)    cnt <= at_last ? '0 : cnt + 1'b1;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flat[8*g +: 8] <= '0;
      else if (take && cnt == CNT_W'(g))   flat[8*g +: 8] <= din;
    end
  end

  // R1: a completed packet restarts byte counting at zero
  assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (cnt == '0));
endmodule

// File: rtl/setup_decoder.sv
module setup_decoder
  import usb_setup_pkg::*;
(
  input  logic [7:0]        rtype,
  input  logic [7:0]        code,
  input  logic [7:0]        val_lo,
  input  logic [7:0]        idx_lo,
  input  logic [7:0]        idx_hi,
  input  logic [7:0]        len_lo,
  input  logic [7:0]        len_hi,
  output req_class_t        cls,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata
);
  logic [15:0] len;
  assign len   = {len_hi, len_lo};
  assign addr  = {idx_hi, idx_lo};
  assign wdata = val_lo;

  always_comb begin
    if (rtype == TYPE_REG_RD && code == CODE_REG)
      cls = (len == 16'd1) ? CLS_RD : CLS_STALL;
    else if (rtype == TYPE_REG_WR && code == CODE_REG)
      cls = CLS_WR;
    else if (rtype[6:5] == KIND_VENDOR)
      cls = CLS_FWD;
    else if (rtype[6:5] == KIND_STD && code == CODE_GET_DESC)
      cls = CLS_FWD;
    else
      cls = CLS_NONE;
  end
endmodule

// File: rtl/fw_setup_buffer.sv
module fw_setup_buffer
  import usb_setup_pkg::*;
#(
  parameter int NBYTES = SETUP_BYTES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [8*NBYTES-1:0]        din,
  input  logic                       irq_clr,
  input  logic [$clog2(NBYTES)-1:0]  rd_idx,
  output logic [7:0]                 rd_byte,
  output logic                       irq
);
  logic [7:0] mem [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem[g] <= '0;
      else if (load) mem[g] <= din[8*g +: 8];
    end
  end

  assign rd_byte = mem[rd_idx];

  // a new packet outranks a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (load)     irq <= 1'b1;
    else if (irq_clr)  irq <= 1'b0;
  end

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> irq);
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !load) |=> !irq);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/usb_setup_bridge.sv
module usb_setup_bridge
  import usb_setup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_valid,
  output logic              setup_ready,
  input  logic [7:0]        setup_data,
  output logic              in_valid,
  input  logic              in_ready,
  output logic [7:0]        in_data,
  output logic              ctl_stall,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata,
  output logic              fw_irq,
  input  logic              fw_irq_clr,
  input  logic [IDX_W-1:0]  fw_idx,
  output logic [7:0]        fw_byte
);
  bridge_state_t      state, state_nx;
  logic [SETUP_BITS-1:0] pkt;
  logic               frame_done;
  logic               take;
  req_class_t         cls;
  logic [ADDR_W-1:0]  dec_addr;
  logic [7:0]         dec_wdata;
  logic               fwd_load;

  assign setup_ready = (state == ST_COLLECT);
  assign take        = setup_valid && setup_ready;
  assign reg_rd      = (state == ST_RDCAP);
  assign fwd_load    = (state == ST_EXEC) && (cls == CLS_FWD);

  setup_collector #(.NBYTES(SETUP_BYTES)) u_collect (
    .clk(clk), .rst_n(rst_n), .take(take), .din(setup_data),
    .flat(pkt), .frame_done(frame_done)
  );

  setup_decoder u_decode (
    .rtype(pkt[7:0]),   .code(pkt[15:8]),  .val_lo(pkt[23:16]),
    .idx_lo(pkt[39:32]), .idx_hi(pkt[47:40]),
    .len_lo(pkt[55:48]), .len_hi(pkt[63:56]),
    .cls(cls), .addr(dec_addr), .wdata(dec_wdata)
  );

  fw_setup_buffer #(.NBYTES(SETUP_BYTES)) u_fwbuf (
    .clk(clk), .rst_n(rst_n), .load(fwd_load), .din(pkt),
    .irq_clr(fw_irq_clr), .rd_idx(fw_idx), .rd_byte(fw_byte), .irq(fw_irq)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_COLLECT: if (frame_done) state_nx = ST_EXEC;
      ST_EXEC:    state_nx = (cls == CLS_RD) ? ST_RDCAP : ST_COLLECT;
      ST_RDCAP:   state_nx = ST_RESP;
      ST_RESP:    if (in_ready) state_nx = ST_COLLECT;
      default:    state_nx = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_COLLECT;
      reg_wr    <= 1'b0;
      ctl_stall <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      in_valid  <= 1'b0;
      in_data   <= '0;
    end else begin
      state     <= state_nx;
      reg_wr    <= (state == ST_EXEC) && (cls == CLS_WR);
      ctl_stall <= (state == ST_EXEC) && (cls == CLS_STALL);
      if (state == ST_EXEC && (cls == CLS_RD || cls == CLS_WR)) begin
        reg_addr  <= dec_addr;
        reg_wdata <= dec_wdata;
      end
      if (state == ST_RDCAP) begin
        in_valid <= 1'b1;
        in_data  <= reg_rdata;
      end else if (state == ST_RESP && in_ready) begin
        in_valid <= 1'b0;
      end
    end
  end

  assert_no_accept_in_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !setup_ready);
  assert_read_feeds_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (in_valid && !reg_rd));
  assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data)));
  assert_stall_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stall |-> (!reg_rd && !in_valid));
  assert_write_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: tb/usb_setup_bridge_test.sv
`timescale 1ns/1ps
module usb_setup_bridge_test;
  localparam int K_NONE = 0, K_RD = 1, K_STALL = 2, K_WR = 3, K_FWD = 4;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [63:0] pkt;   // hex reads {len, index, value, code, type}
    logic [2:0]  kind;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{64'h0001_1234_0000_00C0, 3'(K_RD)},
    '{64'h0002_0042_0000_00C0, 3'(K_STALL)},
    '{64'h0000_00A5_0000_00C0, 3'(K_STALL)},
    '{64'h0000_00F0_773C_0041, 3'(K_WR)},
    '{64'h0012_0000_0100_0680, 3'(K_FWD)},
    '{64'h0004_0010_0000_05C0, 3'(K_FWD)},
    '{64'h0000_0003_0009_0741, 3'(K_FWD)},
    '{64'h0000_0000_0007_0500, 3'(K_NONE)},
    '{64'h0008_0000_0200_0921, 3'(K_NONE)},
    '{64'h0001_BEEF_0000_00C0, 3'(K_RD)}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_valid = 1'b0, in_ready = 1'b0, fw_irq_clr = 1'b0;
  logic [7:0] setup_data = '0;
  logic [2:0] fw_idx = '0;
  logic setup_ready, in_valid, ctl_stall, reg_wr, reg_rd, fw_irq;
  logic [7:0] in_data, reg_wdata, reg_rdata, fw_byte;
  logic [15:0] reg_addr;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, st_cnt = 0;
  logic [15:0] wr_a, rd_a;
  logic [7:0]  wr_d;
  logic [63:0] last_fwd = '0;

  always #2.5 clk = ~clk;

  // register bus model: read data is a fixed function of the address
  assign reg_rdata = reg_addr[15:8] ^ reg_addr[7:0] ^ 8'h5A;

  usb_setup_bridge uut (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_ready(setup_ready),
    .setup_data(setup_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ctl_stall(ctl_stall), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .fw_irq(fw_irq), .fw_irq_clr(fw_irq_clr), .fw_idx(fw_idx), .fw_byte(fw_byte)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wr)    begin wr_cnt++; wr_a = reg_addr; wr_d = reg_wdata; end
      if (reg_rd)    begin rd_cnt++; rd_a = reg_addr; end
      if (ctl_stall) st_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  task automatic clear_counts();
    wr_cnt = 0; rd_cnt = 0; st_cnt = 0;
  endtask

  task automatic send(input logic [63:0] p);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      while (!setup_ready) @(negedge clk);
      setup_valid = 1'b1;
      setup_data  = p[8*i +: 8];
    end
    @(negedge clk);
    setup_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_buffer(input logic [63:0] exp, input string tag);
    logic [63:0] got;
    for (int i = 0; i < 8; i++) begin
      fw_idx = 3'(i);
      #0.1;
      got[8*i +: 8] = fw_byte;
    end
    chk(got == exp, tag, got, exp);
  endtask

  task automatic take_data();
    in_ready = 1'b1;
    @(negedge clk);
    in_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    fw_irq_clr = 1'b1;
    @(negedge clk);
    fw_irq_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk(setup_ready == 1'b1 && in_valid == 1'b0 && fw_irq == 1'b0 && !reg_wr && !reg_rd,
        "R1 reset", {setup_ready, in_valid, fw_irq, reg_wr, reg_rd}, 64'h10);
    rst_n = 1'b1;
    wait_cyc(2);
    check_buffer(64'h0, "R6 reset buffer");

    for (int v = 0; v < NVEC; v++) begin
      logic [63:0] p;
      p = VECS[v].pkt;
      clear_counts();
      send(p);
      wait_cyc(3);
      case (int'(VECS[v].kind))
        K_RD: begin
          chk(rd_cnt == 1 && rd_a == p[47:32], "R2 read strobe/addr", {rd_cnt, rd_a}, {32'd1, p[47:32]});
          chk(in_valid && in_data == exp_rd(p[47:32]), "R2 data stage",
              {in_valid, in_data}, {1'b1, exp_rd(p[47:32])});
          chk(!setup_ready, "R1 ready low in data stage", setup_ready, 0);
          take_data();
          chk(!in_valid && setup_ready, "R1 data taken", {in_valid, setup_ready}, 1);
        end
        K_STALL:
          chk(st_cnt == 1 && rd_cnt == 0 && !in_valid && !fw_irq, "R3 stall",
              {st_cnt, rd_cnt, in_valid, fw_irq}, {32'd1, 32'd0});
        K_WR:
          chk(wr_cnt == 1 && wr_a == p[47:32] && wr_d == p[23:16] && !in_valid && !fw_irq,
              "R4 write", {wr_cnt, wr_a, wr_d}, {32'd1, p[47:32], p[23:16]});
        K_FWD: begin
          chk(fw_irq && wr_cnt == 0 && rd_cnt == 0 && st_cnt == 0, "R5 forward irq",
              {fw_irq, wr_cnt, rd_cnt}, 64'h1);
          check_buffer(p, "R6 buffer contents");
          last_fwd = p;
          pulse_clr();
          chk(!fw_irq, "R7 irq cleared", fw_irq, 0);
        end
        default: begin
          chk(!fw_irq && wr_cnt == 0 && rd_cnt == 0 && st_cnt == 0 && setup_ready,
              "R8 ignored request", {fw_irq, wr_cnt, rd_cnt, st_cnt}, 0);
          check_buffer(last_fwd, "R8 buffer unchanged");
        end
      endcase
    end

    // R7: second forwarded packet without a clear overwrites and keeps irq
    send(64'h0040_0000_0200_0680);
    wait_cyc(2);
    send(64'h0001_0055_00AA_09C0);
    wait_cyc(2);
    chk(fw_irq, "R7 irq held across packets", fw_irq, 1);
    check_buffer(64'h0001_0055_00AA_09C0, "R7 overwrite");
    wait_cyc(3);
    chk(fw_irq, "R7 irq holds without clear", fw_irq, 1);
    pulse_clr();

    // R1/R2: junk pushed while data stage waits must not be accepted
    clear_counts();
    send(64'h0001_0707_0000_00C0);
    wait_cyc(2);
    setup_valid = 1'b1;
    setup_data  = 8'hEE;
    for (int i = 0; i < 4; i++) begin
      chk(in_valid && in_data == exp_rd(16'h0707) && !setup_ready, "R2 hold under back-pressure",
          {in_valid, in_data, setup_ready}, {1'b1, exp_rd(16'h0707), 1'b0});
      @(negedge clk);
    end
    setup_valid = 1'b0;
    take_data();
    clear_counts();
    send(64'h0000_ABCD_0011_0041);
    wait_cyc(3);
    chk(wr_cnt == 1 && wr_a == 16'hABCD && wr_d == 8'h11, "R1 no junk accepted / R4",
        {wr_cnt, wr_a, wr_d}, {32'd1, 16'hABCD, 8'h11});
    chk(!fw_irq && !in_valid, "R4 no data stage", {fw_irq, in_valid}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule